// File: doc/BRIEF.md
# Clock-Loss Watchdog with Sticky Failover

This block supervises an external reference clock with the help of a separate, always-running backup oscillator. A short counter runs on the backup clock. A synchronizer samples the external clock level in the backup domain, and every rising or falling transition it sees resets the counter. If the counter runs through its full span without a reset, the external clock is declared lost. The system clock output then moves to the backup clock and an interrupt request is raised.

Failover is sticky. Once the external clock has been judged lost, the block stays on the backup clock even if external edges come back. Only a reset selects the external clock again. A configuration write can turn monitoring off. While monitoring is off and no failover has occurred, the system clock is the external clock and a power-down request for the backup oscillator is asserted. All control inputs are synchronous to the backup clock.

Top module: `clkmon_failover`

## Requirements
- R1: After reset, `failover`, `irq` and `osc_pd` are 0 and `sys_clk` follows `ext_clk`. Monitoring is enabled by default.
- R2: A write with `cfg_we`=1 and bit `MON_DIS_BIT` (default 4) of `cfg_wdata` at 1 turns monitoring off. While monitoring is off, a stopped external clock never causes failover, and `osc_pd` is 1. A write with that bit at 0 turns monitoring back on and drops `osc_pd`.
- R3: Both rising and falling external transitions clear the loss counter. Transitions spaced 16 backup cycles apart or closer never cause failover.
- R4: Failover is declared once OVF_CYCLES (16) backup cycles pass without a transition. Transitions spaced 17 cycles apart cause failover. After the external clock stops, failover asserts after more than 12 and at most 24 backup cycles.
- R5: On failover, `irq` is set in the same cycle as `failover`. Within a few backup cycles `sys_clk` follows `bkp_clk`, and the backup path is only ever enabled after failover.
- R6: `failover` and the backup clock selection stay in place when external edges return and when monitoring is turned off afterwards. In that state `osc_pd` stays 0.
- R7: A one-cycle `irq_ack` pulse clears `irq` without affecting `failover`. `irq` is not raised again while the failover persists.
- R8: A reset after failover restores the external clock on `sys_clk` and clears `failover` and `irq`.
- R9: While monitoring is off and no failover has occurred, `sys_clk` follows `ext_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bkp_clk | input | 1 | Free-running backup clock; clocks the monitor |
| ext_clk | input | 1 | External reference clock being supervised |
| rst | input | 1 | Synchronous active-high reset (backup domain) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W | Configuration write data; bit MON_DIS_BIT disables monitoring |
| irq_ack | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| sys_clk | output | 1 | Glitch-free selected system clock |
| failover | output | 1 | Sticky indication that the backup clock is in use |
| irq | output | 1 | Oscillator-failure interrupt request |
| osc_pd | output | 1 | Request to power down the backup oscillator |

## Verification
The bench uses the default parameters: a 16-cycle loss limit, a two-stage synchronizer and a two-cycle switch guard. With these values the exact loss boundary can be driven directly. The external clock is toggled from the backup clock, once every 16 cycles and once every 17, so the difference of one cycle decides whether failover occurs. The short guard lets the bench compare `sys_clk` against each source clock a few cycles after every selection change, in both the monitored and the disabled configuration.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    typedef enum logic [1:0] {
        MON_ACTIVE = 2'd0,
        MON_IDLE   = 2'd1,
        MON_FAILED = 2'd2
    } mon_state_e;

    typedef struct packed {
        logic failed;
        logic irq;
        logic pd_req;
    } mon_status_t;

    function automatic int cnt_width(input int span);
        return (span <= 2) ? 1 : $clog2(span);
    endfunction

endpackage

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_lvl,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= async_lvl;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], async_lvl};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign edge_o = sync_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/clkmon_loss_ctr.sv
module clkmon_loss_ctr
    import clkmon_pkg::*;
#(
    parameter int OVF_CYCLES = 16,
    parameter int CNT_W      = cnt_width(OVF_CYCLES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_dis,
    input  logic             ext_edge,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dis_o,
    output mon_status_t      status_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(OVF_CYCLES - 1);

    mon_state_e       st_q, st_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             dis_q;
    logic             irq_q;
    logic             fail_enter;

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            MON_ACTIVE: begin
                if (dis_q)                          st_nxt = MON_IDLE;
                else if (!ext_edge && cnt_q == LIMIT) st_nxt = MON_FAILED;
            end
            MON_IDLE:   if (!dis_q) st_nxt = MON_ACTIVE;
            MON_FAILED: st_nxt = MON_FAILED;
            default:    st_nxt = MON_ACTIVE;
        endcase
    end

    assign fail_enter = (st_q != MON_FAILED) && (st_nxt == MON_FAILED);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= MON_ACTIVE;
            cnt_q <= '0;
            dis_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            st_q <= st_nxt;
            if (cfg_we) dis_q <= cfg_dis;
            if (st_q != MON_ACTIVE || dis_q || ext_edge) cnt_q <= '0;
            else if (cnt_q != LIMIT)                     cnt_q <= cnt_q + 1'b1;
            if (fail_enter)   irq_q <= 1'b1;
            else if (irq_ack) irq_q <= 1'b0;
        end
    end

    assign cnt_o           = cnt_q;
    assign dis_o           = dis_q;
    assign status_o.failed = (st_q == MON_FAILED);
    assign status_o.irq    = irq_q;
    assign status_o.pd_req = dis_q && (st_q != MON_FAILED);
endmodule

// File: rtl/clkmon_clk_switch.sv
module clkmon_clk_switch #(
    parameter int GUARD_CYC   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic bkp_clk,
    input  logic ext_clk,
    input  logic rst,
    input  logic sel_bkp,
    output logic en_bkp_o,
    output logic sys_clk
);
    localparam int GW = (GUARD_CYC < 1) ? 1 : $clog2(GUARD_CYC + 1);
    localparam logic [GW-1:0] GUARD = GW'(GUARD_CYC);

    logic [GW-1:0]          guard_q;
    logic                   ext_ok_q;
    logic                   en_bkp_q;
    logic [SYNC_STAGES-1:0] ext_sync_q;
    logic                   en_ext_q;

    always_ff @(posedge bkp_clk) begin
        if (rst) begin
            guard_q  <= '0;
            ext_ok_q <= 1'b0;
        end else begin
            if (sel_bkp && guard_q != GUARD) guard_q <= guard_q + 1'b1;
            ext_ok_q <= !sel_bkp && !en_bkp_q;
        end
    end

    always_ff @(negedge bkp_clk) begin
        if (rst) en_bkp_q <= 1'b0;
        else     en_bkp_q <= sel_bkp && (guard_q == GUARD);
    end

    generate
        if (SYNC_STAGES == 1) begin : g_ext1
            always_ff @(negedge ext_clk) ext_sync_q <= ext_ok_q;
        end else begin : g_extn
            always_ff @(negedge ext_clk)
                ext_sync_q <= {ext_sync_q[SYNC_STAGES-2:0], ext_ok_q};
        end
    endgenerate

    always_ff @(negedge ext_clk) en_ext_q <= ext_sync_q[SYNC_STAGES-1];

    assign en_bkp_o = en_bkp_q;
    assign sys_clk  = (ext_clk & en_ext_q & ~sel_bkp) | (bkp_clk & en_bkp_q);
endmodule

// File: rtl/clkmon_failover.sv
module clkmon_failover
    import clkmon_pkg::*;
#(
    parameter int OVF_CYCLES  = 16,
    parameter int GUARD_CYC   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int CFG_W       = 16,
    parameter int MON_DIS_BIT = 4
) (
    input  logic             bkp_clk,
    input  logic             ext_clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             irq_ack,
    output logic             sys_clk,
    output logic             failover,
    output logic             irq,
    output logic             osc_pd
);
    localparam int CNT_W = cnt_width(OVF_CYCLES);

    logic             ext_edge;
    logic [CNT_W-1:0] mon_cnt;
    logic             mon_dis;
    logic             en_bkp;
    mon_status_t      mon_st;

    clkmon_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (bkp_clk),
        .rst       (rst),
        .async_lvl (ext_clk),
        .edge_o    (ext_edge)
    );

    clkmon_loss_ctr #(.OVF_CYCLES(OVF_CYCLES), .CNT_W(CNT_W)) u_ctr (
        .clk      (bkp_clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_dis  (cfg_wdata[MON_DIS_BIT]),
        .ext_edge (ext_edge),
        .irq_ack  (irq_ack),
        .cnt_o    (mon_cnt),
        .dis_o    (mon_dis),
        .status_o (mon_st)
    );

    clkmon_clk_switch #(.GUARD_CYC(GUARD_CYC), .SYNC_STAGES(SYNC_STAGES)) u_sw (
        .bkp_clk  (bkp_clk),
        .ext_clk  (ext_clk),
        .rst      (rst),
        .sel_bkp  (mon_st.failed),
        .en_bkp_o (en_bkp),
        .sys_clk  (sys_clk)
    );

    assign failover = mon_st.failed;
    assign irq      = mon_st.irq;
    assign osc_pd   = mon_st.pd_req;
endmodule

// File: rtl/clkmon_failover_chk.sv
module clkmon_failover_chk #(
    parameter int OVF_CYCLES = 16,
    parameter int CNT_W      = 4
) (
    input logic             bkp_clk,
    input logic             rst,
    input logic             ext_edge,
    input logic [CNT_W-1:0] mon_cnt,
    input logic             mon_dis,
    input logic             en_bkp,
    input logic             irq_ack,
    input logic             failover,
    input logic             irq,
    input logic             osc_pd
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(OVF_CYCLES - 1);

    AST_EDGE_CLEARS: assert property (@(posedge bkp_clk) disable iff (rst)
        ext_edge |=> (mon_cnt == '0)); // R3
    AST_FAIL_AT_LIMIT: assert property (@(posedge bkp_clk) disable iff (rst)
        $rose(failover) |-> ($past(mon_cnt) == LIMIT)); // R4
    AST_NO_FAIL_WHEN_OFF: assert property (@(posedge bkp_clk) disable iff (rst)
        $rose(failover) |-> !$past(mon_dis)); // R2
    AST_PD_ONLY_IDLE: assert property (@(posedge bkp_clk) disable iff (rst)
        osc_pd |-> (mon_dis && !failover)); // R2
    AST_IRQ_WITH_FAIL: assert property (@(posedge bkp_clk) disable iff (rst)
        $rose(failover) |-> irq); // R5
    AST_BKP_AFTER_FAIL: assert property (@(posedge bkp_clk) disable iff (rst)
        en_bkp |-> failover); // R5
    AST_FAIL_STICKY: assert property (@(posedge bkp_clk) disable iff (rst)
        failover |=> failover); // R6
    AST_ACK_CLEARS: assert property (@(posedge bkp_clk) disable iff (rst)
        (irq_ack && failover) |=> !irq); // R7
endmodule

bind clkmon_failover clkmon_failover_chk #(.OVF_CYCLES(OVF_CYCLES), .CNT_W(CNT_W)) u_chk (
    .bkp_clk  (bkp_clk),
    .rst      (rst),
    .ext_edge (ext_edge),
    .mon_cnt  (mon_cnt),
    .mon_dis  (mon_dis),
    .en_bkp   (en_bkp),
    .irq_ack  (irq_ack),
    .failover (failover),
    .irq      (irq),
    .osc_pd   (osc_pd)
);

// File: tb/sim_clkmon_failover.sv
`timescale 1ns/1ps
module sim_clkmon_failover;
    logic        bkp_clk = 1'b0;
    logic        ext_clk = 1'b0;
    logic        rst     = 1'b1;
    logic        cfg_we  = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        irq_ack = 1'b0;
    logic        sys_clk, failover, irq, osc_pd;

    int  n_run  = 0;
    int  n_fail = 0;
    int  ext_half = 4;
    bit  ext_run  = 1'b1;
    bit  done     = 1'b0;
    int  cyc      = 0;

    clkmon_failover u0 (
        .bkp_clk(bkp_clk), .ext_clk(ext_clk), .rst(rst), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .irq_ack(irq_ack), .sys_clk(sys_clk),
        .failover(failover), .irq(irq), .osc_pd(osc_pd)
    );

    always #4 bkp_clk = ~bkp_clk;

    // external clock: toggles every ext_half backup cycles while running
    initial begin
        int k = 0;
        forever begin
            @(negedge bkp_clk);
            #1;
            if (ext_run) begin
                k++;
                if (k >= ext_half) begin
                    ext_clk = ~ext_clk;
                    k = 0;
                end
            end else k = 0;
        end
    end

    always @(posedge bkp_clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected=<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge bkp_clk);
        #2;
    endtask

    task automatic cfg_write(input logic dis);
        @(posedge bkp_clk); #2;
        cfg_we = 1'b1; cfg_wdata = '0; cfg_wdata[4] = dis;
        @(posedge bkp_clk); #2;
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic clk_mismatch(input bit want_bkp, output int m);
        m = 0;
        for (int i = 0; i < 16; i++) begin
            @(posedge bkp_clk); #2;
            if (sys_clk !== (want_bkp ? bkp_clk : ext_clk)) m++;
            @(negedge bkp_clk); #2;
            if (sys_clk !== (want_bkp ? bkp_clk : ext_clk)) m++;
        end
    endtask

    task automatic do_reset();
        ext_half = 4; ext_run = 1'b1; rst = 1'b1;
        wait_cyc(6);
        rst = 1'b0;
        wait_cyc(60);
    endtask

    task automatic t_reset_state();
        int m;
        do_reset();
        chk(failover == 1'b0, "R1", "failover after reset", failover, 0);
        chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
        chk(osc_pd == 1'b0, "R1", "osc_pd after reset", osc_pd, 0);
        clk_mismatch(1'b0, m);
        chk(m == 0, "R1", "sys_clk vs ext_clk mismatches", m, 0);
    endtask

    task automatic t_edge_spacing_ok();
        ext_half = 16;
        wait_cyc(300);
        chk(failover == 1'b0, "R3", "failover at 16-cycle spacing", failover, 0);
        ext_half = 3;
        wait_cyc(100);
        chk(failover == 1'b0, "R3", "failover at 3-cycle spacing", failover, 0);
        ext_half = 4;
        wait_cyc(20);
    endtask

    task automatic t_disable();
        int m;
        cfg_write(1'b1);
        ext_run = 1'b0;
        wait_cyc(60);
        chk(failover == 1'b0, "R2", "failover while disabled and ext stopped", failover, 0);
        chk(osc_pd == 1'b1, "R2", "osc_pd while disabled", osc_pd, 1);
        ext_run = 1'b1;
        wait_cyc(40);
        clk_mismatch(1'b0, m);
        chk(m == 0, "R9", "sys_clk vs ext_clk while disabled", m, 0);
        cfg_write(1'b0);
        wait_cyc(30);
        chk(osc_pd == 1'b0, "R2", "osc_pd after re-enable", osc_pd, 0);
        chk(failover == 1'b0, "R2", "failover after re-enable", failover, 0);
    endtask

    task automatic t_stop_detect();
        int m;
        ext_run = 1'b0;
        wait_cyc(12);
        chk(failover == 1'b0, "R4", "failover 12 cycles after stop", failover, 0);
        wait_cyc(12);
        chk(failover == 1'b1, "R4", "failover 24 cycles after stop", failover, 1);
        chk(irq == 1'b1, "R5", "irq after failover", irq, 1);
        wait_cyc(10);
        clk_mismatch(1'b1, m);
        chk(m == 0, "R5", "sys_clk vs bkp_clk after failover", m, 0);
        chk(osc_pd == 1'b0, "R5", "osc_pd after failover", osc_pd, 0);
    endtask

    task automatic t_sticky();
        int m;
        ext_run = 1'b1;
        wait_cyc(60);
        chk(failover == 1'b1, "R6", "failover with ext back", failover, 1);
        clk_mismatch(1'b1, m);
        chk(m == 0, "R6", "sys_clk stays on bkp with ext back", m, 0);
        cfg_write(1'b1);
        wait_cyc(20);
        chk(failover == 1'b1, "R6", "failover after disable", failover, 1);
        chk(osc_pd == 1'b0, "R6", "osc_pd after disable in failover", osc_pd, 0);
        clk_mismatch(1'b1, m);
        chk(m == 0, "R6", "sys_clk on bkp after disable", m, 0);
    endtask

    task automatic t_irq_ack();
        @(posedge bkp_clk); #2;
        irq_ack = 1'b1;
        @(posedge bkp_clk); #2;
        irq_ack = 1'b0;
        chk(irq == 1'b0, "R7", "irq after ack", irq, 0);
        chk(failover == 1'b1, "R7", "failover after ack", failover, 1);
        wait_cyc(30);
        chk(irq == 1'b0, "R7", "irq stays clear", irq, 0);
    endtask

    task automatic t_reset_restore();
        int m;
        do_reset();
        chk(failover == 1'b0, "R8", "failover after reset", failover, 0);
        chk(irq == 1'b0, "R8", "irq after reset", irq, 0);
        clk_mismatch(1'b0, m);
        chk(m == 0, "R8", "sys_clk back on ext", m, 0);
    endtask

    task automatic t_edge_spacing_17();
        ext_half = 17;
        wait_cyc(100);
        chk(failover == 1'b1, "R4", "failover at 17-cycle spacing", failover, 1);
        chk(irq == 1'b1, "R5", "irq at 17-cycle spacing", irq, 1);
    endtask

    initial begin
        t_reset_state();
        t_edge_spacing_ok();
        t_disable();
        t_stop_detect();
        t_sticky();
        t_irq_ack();
        t_reset_restore();
        t_edge_spacing_17();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule